// File: doc/BRIEF.md
# Sampling Capacitor Ring Manager

This block keeps the books for a ring of analog sampling capacitors that is shared by all channels of a front-end board. The ring holds 12 blocks of 8 cells. A sample is written every second tick of the 40 MHz clock, so the rate is 20 MHz. Cell addresses are issued in Gray code. The writer moves around the ring one block at a time and steps over any block that is reserved.

A local trigger reserves the two most recently completed blocks. The group is tagged with a 4-bit crossing count and then waits for an accept. The accept must arrive within one crossing either side of a programmable latency. A matched group joins a small queue and is handed to the digitizer in arrival order. While the digitizer works, a read address is generated alongside the running writes. The group's blocks are released when the digitizer reports done. A group that gets no accept in its window is released at once. A trigger that cannot be served is dropped, and a sticky overflow flag records the loss.

Top module: `sample_ring_mgr`

## Requirements
- R1: While reset is asserted and in the first cycle after it, wr_en_o, wr_addr_o, rd_valid_o, dig_start_o and ovf_o are all 0. The writer starts on cell 0 of block 0. The crossing counter starts at 0.
- R2: wr_en_o is low in the first cycle after reset and then toggles on every clock. Each address is held for two cycles and is written in the second of them. The 8 cells of a block are written in order 0 to 7. The writer then moves to the nearest unreserved block in ascending ring order (11 wraps to 0), judged on the reservations that hold after that same edge. If no other block is free, it stays in the same block.
- R3: Every address is the Gray code g = n ^ (n >> 1) of the linear cell number n = block*8 + cell, which runs from 0 to 95. The output is 7 bits wide.
- R4: A served trigger reserves the two most recently completed blocks. The older one is group block a and the newer one is block b. No reserved block is written until it is released.
- R5: The group tag is the value of a 4-bit counter in the trigger cycle. The counter is 0 in the first cycle after reset and adds 1 on every clock.
- R6: Say an accept is sampled k clocks after the edge that sampled a trigger. It matches the oldest waiting group when max(lat-1,1) <= k <= lat+1. Any other accept is ignored.
- R7: A waiting group with no match is released at the edge where k reaches lat+1. A later accept then finds nothing to match.
- R8: A trigger is dropped in any of these cases: fewer than two blocks have completed since reset; either candidate block is already reserved; either candidate block is the one being written; the two candidates are the same block; fewer than 4 blocks are unreserved; or 4 groups are already waiting. A matched group is dropped and released when 4 accepted groups are already queued. Every drop sets ovf_o, which stays set until reset.
- R9: Accepted groups are digitized in arrival order. dig_start_o pulses for one cycle. It appears two edges after the matching accept when the digitizer is idle, and otherwise the edge after the digitizer frees up. dig_blk_a_o, dig_blk_b_o and dig_tag_o carry the group and hold until the next start.
- R10: rd_valid_o is high from the start pulse until the edge that samples done_i. rd_addr_o steps one cell per clock through cells 0 to 7 of block a and then cells 0 to 7 of block b, in the same Gray code as R3, and holds on the last cell. The done edge releases both blocks. done_i is ignored while rd_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Local trigger, one cycle per trigger |
| accept_i | input | 1 | Accept, one cycle per accept |
| lat_i | input | 8 | Expected trigger-to-accept latency in clocks |
| done_i | input | 1 | Digitizer finished the current group |
| wr_en_o | output | 1 | Write strobe for the current address |
| wr_addr_o | output | 7 | Gray-coded write cell address |
| rd_valid_o | output | 1 | Read address is valid; digitization running |
| rd_addr_o | output | 7 | Gray-coded read cell address |
| dig_start_o | output | 1 | One-cycle start request to the digitizer |
| dig_blk_a_o | output | 4 | First block of the group being digitized |
| dig_blk_b_o | output | 4 | Second block of the group being digitized |
| dig_tag_o | output | 4 | Crossing tag of the group being digitized |
| ovf_o | output | 1 | Sticky flag for a dropped trigger or group |

## Verification
A stale reservation bit shows up within one block time, at most 16 clocks later. Either the writer lands on a block that should have been skipped, or it skips one that should be free, and the write address departs from the independent ring model. A wrong match-window bound or queue pointer shows up at the next accept. It appears as a missing or extra dig_start_o pulse, or as the wrong blocks or tag two edges after the accept. A leaked block shows up later, as an unexpected overflow or a shifted writer path.

// File: rtl/sca_mgr_pkg.sv
package sca_mgr_pkg;
  parameter int unsigned BLK_N    = 12;
  parameter int unsigned CELL_N   = 8;
  parameter int unsigned TAG_W    = 4;
  parameter int unsigned BLK_W    = $clog2(BLK_N);
  parameter int unsigned CELL_W   = $clog2(CELL_N);
  parameter int unsigned ADDR_W   = BLK_W + CELL_W;
  parameter int unsigned GRP_BLKS = 2;

  typedef logic [BLK_W-1:0] blk_t;

  typedef struct packed {
    blk_t             a;
    blk_t             b;
    logic [TAG_W-1:0] tag;
  } grp_t;

  function automatic logic [ADDR_W-1:0] gray_addr(blk_t b, logic [CELL_W-1:0] c);
    logic [ADDR_W-1:0] n;
    n = {b, c};
    return n ^ (n >> 1);
  endfunction

  function automatic logic [BLK_N-1:0] grp_mask(grp_t g);
    logic [BLK_N-1:0] m;
    m = '0;
    m[g.a] = 1'b1;
    m[g.b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/grp_fifo.sv
module grp_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= inc(wr_q);
      end
      if (do_pop) rd_q <= inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ring_writer.sv
module ring_writer
  import sca_mgr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_N-1:0]  rsv_next_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output blk_t              cur_o,
  output blk_t              h0_o,
  output blk_t              h1_o,
  output logic              hist_ok_o
);
  logic              phase_q;
  logic [CELL_W-1:0] cell_q;
  blk_t              cur_q, h0_q, h1_q, nxt_blk;
  logic [1:0]        hn_q;

  // nearest unreserved block after the current one, ring order
  always_comb begin
    nxt_blk = cur_q;
    for (int i = int'(BLK_N) - 1; i >= 1; i--) begin
      int j;
      j = int'(cur_q) + i;
      if (j >= int'(BLK_N)) j = j - int'(BLK_N);
      if (!rsv_next_i[j]) nxt_blk = blk_t'(j);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cell_q  <= '0;
      cur_q   <= '0;
      h0_q    <= '0;
      h1_q    <= '0;
      hn_q    <= '0;
    end else begin
      phase_q <= !phase_q;
      if (phase_q) begin
        if (cell_q == CELL_W'(CELL_N - 1)) begin
          cell_q <= '0;
          h1_q   <= h0_q;
          h0_q   <= cur_q;
          cur_q  <= nxt_blk;
          if (hn_q != 2'd2) hn_q <= hn_q + 2'd1;
        end else begin
          cell_q <= cell_q + CELL_W'(1);
        end
      end
    end
  end

  assign wr_en_o   = phase_q;
  assign wr_addr_o = gray_addr(cur_q, cell_q);
  assign cur_o     = cur_q;
  assign h0_o      = h0_q;
  assign h1_o      = h1_q;
  assign hist_ok_o = (hn_q == 2'd2);
endmodule

// File: rtl/dig_ctrl.sv
module dig_ctrl
  import sca_mgr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              q_empty_i,
  input  grp_t              q_data_i,
  input  logic              done_i,
  output logic              pop_o,
  output logic              start_o,
  output grp_t              grp_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [BLK_N-1:0]  free_o
);
  localparam int unsigned RC_W = CELL_W + 1;

  logic            busy_q, start_q;
  logic [RC_W-1:0] cnt_q;
  grp_t            grp_q;

  assign pop_o = !busy_q && !q_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
      grp_q   <= '0;
    end else begin
      start_q <= pop_o;
      if (pop_o) begin
        busy_q <= 1'b1;
        grp_q  <= q_data_i;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (done_i) busy_q <= 1'b0;
        if (cnt_q != '1) cnt_q <= cnt_q + RC_W'(1);
      end
    end
  end

  assign start_o    = start_q;
  assign grp_o      = grp_q;
  assign rd_valid_o = busy_q;
  assign rd_addr_o  = gray_addr(cnt_q[CELL_W] ? grp_q.b : grp_q.a, cnt_q[CELL_W-1:0]);
  assign free_o     = (busy_q && done_i) ? grp_mask(grp_q) : '0;
endmodule

// File: rtl/sample_ring_mgr.sv
module sample_ring_mgr
  import sca_mgr_pkg::*;
#(
  parameter int unsigned LAT_W      = 8,
  parameter int unsigned PEND_DEPTH = 4,
  parameter int unsigned DIG_DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              accept_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              done_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              dig_start_o,
  output logic [BLK_W-1:0]  dig_blk_a_o,
  output logic [BLK_W-1:0]  dig_blk_b_o,
  output logic [TAG_W-1:0]  dig_tag_o,
  output logic              ovf_o
);
  localparam int unsigned STAMP_W  = LAT_W + 2;
  localparam int unsigned GRP_W    = $bits(grp_t);
  localparam int unsigned PEND_W   = GRP_W + STAMP_W;
  localparam int unsigned MIN_FREE = GRP_BLKS + 2;

  logic [BLK_N-1:0]   rsv_q, rsv_d, set_m, free_m, dig_free;
  logic [STAMP_W-1:0] tick_q;
  logic [TAG_W-1:0]   xing_q;
  logic               ovf_q;

  blk_t cur, h0, h1;
  logic hist_ok;

  ring_writer u_writer (
    .clk_i, .rst_ni,
    .rsv_next_i (rsv_d),
    .wr_en_o, .wr_addr_o,
    .cur_o (cur), .h0_o (h0), .h1_o (h1), .hist_ok_o (hist_ok)
  );

  // trigger admission
  grp_t new_grp;
  logic trig_ok, p_push, p_pop, p_empty, p_full;
  logic [PEND_W-1:0]  p_rdata;
  grp_t               p_head;
  logic [STAMP_W-1:0] p_stamp;

  assign new_grp.a   = h1;
  assign new_grp.b   = h0;
  assign new_grp.tag = xing_q;
  assign trig_ok = hist_ok && !rsv_q[h0] && !rsv_q[h1] && (h0 != cur) && (h1 != cur)
                   && (h0 != h1) && !p_full && ($countones(~rsv_q) >= MIN_FREE);
  assign p_push  = trig_i && trig_ok;

  grp_fifo #(.W(PEND_W), .DEPTH(PEND_DEPTH)) u_pend (
    .clk_i, .rst_ni,
    .push_i (p_push), .data_i ({new_grp, tick_q}),
    .pop_i (p_pop), .data_o (p_rdata),
    .empty_o (p_empty), .full_o (p_full)
  );
  assign {p_head, p_stamp} = p_rdata;

  // match window on the oldest waiting group
  logic [STAMP_W-1:0] age, lat_ext, win_lo, win_hi;
  logic in_win, hit, expire, d_push, d_pop, d_empty, d_full;
  grp_t d_head;

  assign age     = tick_q - p_stamp;
  assign lat_ext = STAMP_W'(lat_i);
  assign win_lo  = (lat_i > LAT_W'(1)) ? lat_ext - STAMP_W'(1) : STAMP_W'(1);
  assign win_hi  = lat_ext + STAMP_W'(1);
  assign in_win  = !p_empty && (age >= win_lo) && (age <= win_hi);
  assign hit     = accept_i && in_win;
  assign expire  = !p_empty && !hit && (age >= win_hi);
  assign p_pop   = hit || expire;
  assign d_push  = hit && !d_full;

  grp_fifo #(.W(GRP_W), .DEPTH(DIG_DEPTH)) u_digq (
    .clk_i, .rst_ni,
    .push_i (d_push), .data_i (p_head),
    .pop_i (d_pop), .data_o (d_head),
    .empty_o (d_empty), .full_o (d_full)
  );

  grp_t dig_grp;
  dig_ctrl u_dig (
    .clk_i, .rst_ni,
    .q_empty_i (d_empty), .q_data_i (d_head), .done_i,
    .pop_o (d_pop), .start_o (dig_start_o), .grp_o (dig_grp),
    .rd_valid_o, .rd_addr_o, .free_o (dig_free)
  );

  // block ledger
  assign free_m = dig_free | ((expire || (hit && d_full)) ? grp_mask(p_head) : '0);
  assign set_m  = p_push ? grp_mask(new_grp) : '0;
  assign rsv_d  = (rsv_q & ~free_m) | set_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsv_q  <= '0;
      tick_q <= '0;
      xing_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      rsv_q  <= rsv_d;
      tick_q <= tick_q + STAMP_W'(1);
      xing_q <= xing_q + TAG_W'(1);
      if ((trig_i && !trig_ok) || (hit && d_full)) ovf_q <= 1'b1;
    end
  end

  assign dig_blk_a_o = dig_grp.a;
  assign dig_blk_b_o = dig_grp.b;
  assign dig_tag_o   = dig_grp.tag;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/sample_ring_chk.sv
module sample_ring_chk
  import sca_mgr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              dig_start_o,
  input logic [BLK_W-1:0]  dig_blk_a_o,
  input logic [BLK_W-1:0]  dig_blk_b_o,
  input logic              ovf_o
);
  function automatic logic [ADDR_W-1:0] g2b(logic [ADDR_W-1:0] g);
    logic [ADDR_W-1:0] b;
    b[ADDR_W-1] = g[ADDR_W-1];
    for (int i = int'(ADDR_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic              seen_q;
  logic [ADDR_W-1:0] wr_bin;
  blk_t              wr_blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign wr_bin = g2b(wr_addr_o);
  assign wr_blk = wr_bin[ADDR_W-1:CELL_W];

  assert_wr_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (wr_en_o != $past(wr_en_o)));

  assert_gray_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(wr_en_o) && ($past(wr_bin[CELL_W-1:0]) != CELL_W'(CELL_N - 1)))
    |-> ($countones(wr_addr_o ^ $past(wr_addr_o)) == 1));

  assert_wr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bin < ADDR_W'(BLK_N * CELL_N));

  assert_rsv_untouched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ((wr_blk != dig_blk_a_o) && (wr_blk != dig_blk_b_o)));

  assert_grp_distinct_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_start_o |-> (dig_blk_a_o != dig_blk_b_o));

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(ovf_o)) |-> ovf_o);

  assert_start_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && dig_start_o) |-> !$past(rd_valid_o));

  assert_rd_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_start_o |-> (rd_valid_o && (rd_addr_o == gray_addr(dig_blk_a_o, '0))));
endmodule

bind sample_ring_mgr sample_ring_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_o     (wr_en_o),
  .wr_addr_o   (wr_addr_o),
  .rd_valid_o  (rd_valid_o),
  .rd_addr_o   (rd_addr_o),
  .dig_start_o (dig_start_o),
  .dig_blk_a_o (dig_blk_a_o),
  .dig_blk_b_o (dig_blk_b_o),
  .ovf_o       (ovf_o)
);

// File: tb/sample_ring_mgr_tb_top.sv
module sample_ring_mgr_tb_top;
  localparam int CLK_PERIOD = 25;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic trig_i = 1'b0, accept_i = 1'b0, done_i = 1'b0;
  logic [7:0] lat_i = 8'd6;
  logic       wr_en_o, rd_valid_o, dig_start_o, ovf_o;
  logic [6:0] wr_addr_o, rd_addr_o;
  logic [3:0] dig_blk_a_o, dig_blk_b_o, dig_tag_o;

  always #(CLK_PERIOD / 2) clk = !clk;

  sample_ring_mgr dut_i (
    .clk_i (clk), .rst_ni, .trig_i, .accept_i, .lat_i, .done_i,
    .wr_en_o, .wr_addr_o, .rd_valid_o, .rd_addr_o,
    .dig_start_o, .dig_blk_a_o, .dig_blk_b_o, .dig_tag_o, .ovf_o
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gray(int v);
    return v ^ (v >> 1);
  endfunction

  // reference model built from the requirements
  int m_phase, m_cell, m_cur, m_h0, m_h1, m_hn, m_tick, m_xing;
  int m_busy, m_rcnt, m_ra, m_rb, m_rt, m_start, m_ovf;
  bit m_rsv[12];
  int pa[4], pb[4], pt[4], ps[4], pn;
  int qa[4], qb[4], qt[4], qn;

  task automatic model_reset();
    m_phase = 0; m_cell = 0; m_cur = 0; m_h0 = 0; m_h1 = 0; m_hn = 0;
    m_tick = 0; m_xing = 0; m_busy = 0; m_rcnt = 0; m_ra = 0; m_rb = 0;
    m_rt = 0; m_start = 0; m_ovf = 0; pn = 0; qn = 0;
    foreach (m_rsv[i]) m_rsv[i] = 0;
  endtask

  task automatic model_step();
    bit rn[12];
    int old_pn, old_qn, age, lo, hi, nfree, ha, hb, htag;
    bit hit, expire, ok;
    old_pn = pn; old_qn = qn;
    rn = m_rsv;
    // done releases, start pops from queue (R9, R10)
    m_start = 0;
    if (m_busy != 0) begin
      if (done_i) begin rn[m_ra] = 0; rn[m_rb] = 0; m_busy = 0; end
      if (m_rcnt < 15) m_rcnt++;
    end else if (old_qn > 0) begin
      m_start = 1; m_busy = 1; m_rcnt = 0;
      m_ra = qa[0]; m_rb = qb[0]; m_rt = qt[0];
      for (int i = 0; i < 3; i++) begin qa[i] = qa[i+1]; qb[i] = qb[i+1]; qt[i] = qt[i+1]; end
      qn--;
    end
    // match window and expiry (R6, R7)
    if (old_pn > 0) begin
      age = (m_tick - ps[0]) & 1023;
      lo = (lat_i > 1) ? int'(lat_i) - 1 : 1;
      hi = int'(lat_i) + 1;
      hit = accept_i && age >= lo && age <= hi;
      expire = !hit && age >= hi;
      ha = pa[0]; hb = pb[0]; htag = pt[0];
      if (hit || expire) begin
        for (int i = 0; i < 3; i++) begin pa[i] = pa[i+1]; pb[i] = pb[i+1]; pt[i] = pt[i+1]; ps[i] = ps[i+1]; end
        pn--;
      end
      if (hit && old_qn < 4) begin
        qa[qn] = ha; qb[qn] = hb; qt[qn] = htag; qn++;
      end else if (expire || hit) begin
        rn[ha] = 0; rn[hb] = 0;
        if (hit) m_ovf = 1;
      end
    end
    // trigger admission (R4, R5, R8)
    if (trig_i) begin
      nfree = 0;
      foreach (m_rsv[i]) if (!m_rsv[i]) nfree++;
      ok = m_hn >= 2 && !m_rsv[m_h0] && !m_rsv[m_h1] && m_h0 != m_cur && m_h1 != m_cur
           && m_h0 != m_h1 && nfree >= 4 && old_pn < 4;
      if (ok) begin
        pa[pn] = m_h1; pb[pn] = m_h0; pt[pn] = m_xing; ps[pn] = m_tick; pn++;
        rn[m_h0] = 1; rn[m_h1] = 1;
      end else m_ovf = 1;
    end
    m_rsv = rn;
    // writer (R2)
    if (m_phase != 0) begin
      if (m_cell == 7) begin
        int nx;
        m_cell = 0; m_h1 = m_h0; m_h0 = m_cur;
        if (m_hn < 2) m_hn++;
        nx = m_cur;
        for (int i = 11; i >= 1; i--) if (!rn[(m_cur + i) % 12]) nx = (m_cur + i) % 12;
        m_cur = nx;
      end else m_cell++;
    end
    m_phase = 1 - m_phase;
    m_tick = (m_tick + 1) & 1023;
    m_xing = (m_xing + 1) & 15;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else         model_step();
  end

  task automatic compare();
    int exp_rd;
    chk(wr_en_o == m_phase[0], "R2", "wr_en", wr_en_o, m_phase);
    chk(int'(wr_addr_o) == gray(m_cur * 8 + m_cell), "R2,R3", "wr_addr", wr_addr_o, gray(m_cur * 8 + m_cell));
    chk(rd_valid_o == m_busy[0], "R10", "rd_valid", rd_valid_o, m_busy);
    if (m_busy != 0) begin
      exp_rd = gray(((m_rcnt >= 8) ? m_rb : m_ra) * 8 + (m_rcnt % 8));
      chk(int'(rd_addr_o) == exp_rd, "R10", "rd_addr", rd_addr_o, exp_rd);
    end
    chk(dig_start_o == m_start[0], "R6,R7,R9", "dig_start", dig_start_o, m_start);
    if (m_start != 0) begin
      chk(int'(dig_blk_a_o) == m_ra, "R4", "blk_a", dig_blk_a_o, m_ra);
      chk(int'(dig_blk_b_o) == m_rb, "R4", "blk_b", dig_blk_b_o, m_rb);
      chk(int'(dig_tag_o) == m_rt, "R5", "tag", dig_tag_o, m_rt);
    end
    chk(ovf_o == m_ovf[0], "R8", "ovf", ovf_o, m_ovf);
  endtask

  task automatic cyc(bit t, bit a, bit d);
    trig_i = t; accept_i = a; done_i = d;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(int lat);
    @(negedge clk);
    rst_ni = 0; trig_i = 0; accept_i = 0; done_i = 0; lat_i = 8'(lat);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(!wr_en_o && wr_addr_o == 0 && !rd_valid_o && !dig_start_o && !ovf_o, "R1",
        "reset outputs", {wr_en_o, wr_addr_o, rd_valid_o, dig_start_o, ovf_o}, 0);
    rst_ni = 1;
    compare();
  endtask

  // counts start pulses over n idle cycles
  task automatic count_starts(int n, int exp, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0);
      if (dig_start_o) seen++;
    end
    chk(seen == exp, req, "start pulses", seen, exp);
  endtask

  task automatic rand_run(int lat, int n);
    do_reset(lat);
    for (int i = 0; i < n; i++)
      cyc($urandom % 20 == 0, $urandom % 10 == 0, $urandom % 8 == 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20250);
    // early trigger: no history yet
    do_reset(6);
    cyc(0, 0, 0); cyc(1, 0, 0);
    chk(ovf_o == 1'b1, "R8", "ovf after early trigger", ovf_o, 1);
    // window edges at lat = 6
    do_reset(6);
    repeat (40) cyc(0, 0, 0);
    cyc(1, 0, 0); repeat (4) cyc(0, 0, 0); cyc(0, 1, 0);
    count_starts(3, 1, "R6 k=lat-1");
    repeat (10) cyc(0, 0, 0); cyc(0, 0, 1);
    chk(!rd_valid_o, "R10", "rd_valid after done", rd_valid_o, 0);
    repeat (20) cyc(0, 0, 0);
    cyc(1, 0, 0); repeat (7) cyc(0, 0, 0); cyc(0, 1, 0);
    count_starts(4, 0, "R7 k=lat+2");
    cyc(0, 0, 1);
    chk(!rd_valid_o, "R10", "done ignored when idle", rd_valid_o, 0);
    cyc(1, 0, 0); repeat (6) cyc(0, 0, 0); cyc(0, 1, 0);
    count_starts(3, 1, "R6 k=lat+1");
    chk(ovf_o == 1'b0, "R8", "no drop in directed run", ovf_o, 0);
    // random runs over several latencies
    rand_run(1, 3000);
    rand_run(12, 4000);
    rand_run(3 + $urandom % 30, 4000);
    rand_run(255, 3000);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule